// File: doc/BRIEF.md
# Dual-Word Fetch Program Counter

This block owns the single program counter of a two-lane, in-order pipeline front end. Each cycle it presents one read address per lane to an instruction memory with a combinational read path. Lane 0 reads at the counter value and lane 1 reads at the next word. The words that come back are captured into one fetch-to-decode holding register per lane. Each holding register keeps the instruction, the address it came from and a valid flag.

With nothing unusual happening, the counter advances by the number of lanes each cycle, so a contiguous pair of words is fetched every cycle. A taken branch from a later stage loads its target instead. A stall freezes the counter and the holding registers. A per-lane squash turns that lane's holding register into an invalid no-operation. Branch evaluation, decode and the memory array itself are outside the block.

Top module: `fetch_pair_pc`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the counter is 0, both lanes are invalid, and both hold the no-operation word 0x0000.
- R2: Lane i reads at address counter+i, modulo 2^16. Lane 0 reads at the counter and lane 1 at counter+1, so lane 1 reads 0x0000 when the counter is 0xFFFF.
- R3: With no redirect and no stall, the counter becomes counter+2 (modulo 2^16) at the next clock edge.
- R4: With redirect asserted, the counter becomes the target address at the next edge, even when stall is also asserted. Odd targets are allowed.
- R5: With stall asserted and no redirect, the counter keeps its value. A lane that is not squashed keeps its valid flag, instruction and address.
- R6: A lane that is neither stalled nor squashed captures, at the next edge, the word read at its address. It also captures that address and sets its valid flag.
- R7: A squashed lane shows valid 0 and instruction 0x0000 after the next edge, whether or not stall is asserted. Squash bit i affects lane i only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| redirect_i | input | 1 | Taken branch; load target next edge |
| target_i | input | 16 | Branch target word address |
| stall_i | input | 1 | Freeze counter and holding registers |
| squash_i | input | 2 | Per-lane nullify (bit i = lane i) |
| imem_addr_o | output | 32 | Read addresses, lane i at bits [16i+15:16i] |
| imem_rdata_i | input | 32 | Read words, lane i at bits [16i+15:16i] |
| dec_valid_o | output | 2 | Holding register valid, bit i = lane i |
| dec_instr_o | output | 32 | Held instructions, lane i at bits [16i+15:16i] |
| dec_pc_o | output | 32 | Held fetch addresses, lane i at bits [16i+15:16i] |

## Verification
The counter itself is visible at the ports every cycle, through the lane 0 read address. A wrong step, a lost redirect or a stall that leaks shows up on that address one edge after the cause. A wrong counter reaches the held instruction and address fields one edge later still. A holding register that ignores squash or stall shows a stale or live word after a single edge. The fault sits in that lane's valid flag and instruction, while the other lane stays correct. Vectors that wrap past 0xFFFF, redirect under stall and squash under stall separate these cases.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

   // Source of the next counter value
   typedef enum logic [1:0] {
      NPC_HOLD = 2'd0,
      NPC_SEQ  = 2'd1,
      NPC_JUMP = 2'd2
   } npc_src_e;

   // Sequential advance for a given lane count, modulo the address width
   function automatic logic [63:0] seq_step(input logic [63:0] pc, input int lanes);
      return pc + 64'(lanes);
   endfunction

endpackage

// File: rtl/fpc_addr_gen.sv
module fpc_addr_gen #(
   parameter int AW    = 16,
   parameter int LANES = 2
) (
   input  logic [AW-1:0]       pc_i,
   output logic [LANES*AW-1:0] addr_o
);

   localparam int AddrBits = LANES * AW;

   if (AW < 2 || AW > 64) begin : g_bad_aw
      $error("fpc_addr_gen: AW out of range");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("fpc_addr_gen: LANES must be at least 1");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == 0) begin : g_base
         assign addr_o[AW-1:0] = pc_i;
      end else begin : g_off
         assign addr_o[i*AW +: AW] = pc_i + AW'(i);
      end
   end

   // Width sanity at elaboration
   if ($bits(addr_o) != AddrBits) begin : g_bad_width
      $error("fpc_addr_gen: address bus width mismatch");
   end

endmodule

// File: rtl/fpc_pc_reg.sv
module fpc_pc_reg
   import fpc_pkg::*;
#(
   parameter int AW                   = 16,
   parameter int STEP                 = 2,
   parameter bit REDIRECT_BEATS_STALL = 1'b1,
   parameter logic [AW-1:0] RESET_PC  = '0
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          redirect_i,
   input  logic [AW-1:0] target_i,
   input  logic          stall_i,
   output logic [AW-1:0] pc_o
);

   localparam logic [AW-1:0] StepVal = AW'(STEP);

   if (STEP < 1) begin : g_bad_step
      $error("fpc_pc_reg: STEP must be positive");
   end

   logic          jump_ok;
   npc_src_e      src;
   logic [AW-1:0] pc_q;
   logic [AW-1:0] pc_d;

   // Variant: whether a taken branch may override a stall
   if (REDIRECT_BEATS_STALL) begin : g_redir_first
      assign jump_ok = redirect_i;
   end else begin : g_stall_first
      assign jump_ok = redirect_i & ~stall_i;
   end

   always_comb begin
      if (jump_ok) begin
         src = NPC_JUMP;
      end else if (stall_i) begin
         src = NPC_HOLD;
      end else begin
         src = NPC_SEQ;
      end
   end

   always_comb begin
      unique case (src)
         NPC_JUMP: pc_d = target_i;
         NPC_SEQ:  pc_d = pc_q + StepVal;
         default:  pc_d = pc_q;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pc_q <= RESET_PC;
      end else begin
         pc_q <= pc_d;
      end
   end

   assign pc_o = pc_q;

   // R3
   pc_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!redirect_i && !stall_i) |=> (pc_o == $past(pc_o) + StepVal));

   // R5
   pc_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!redirect_i && stall_i) |=> $stable(pc_o));

   if (REDIRECT_BEATS_STALL) begin : g_jump_chk
      // R4
      pc_jump_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         redirect_i |=> (pc_o == $past(target_i)));
   end

endmodule

// File: rtl/fpc_lane_hold.sv
module fpc_lane_hold #(
   parameter int AW                   = 16,
   parameter int IW                   = 16,
   parameter logic [IW-1:0] NOP_WORD  = '0
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          kill_i,
   input  logic          stall_i,
   input  logic [IW-1:0] word_i,
   input  logic [AW-1:0] fpc_i,
   output logic          valid_o,
   output logic [IW-1:0] instr_o,
   output logic [AW-1:0] pc_o
);

   if (IW < 1 || AW < 1) begin : g_bad_width
      $error("fpc_lane_hold: widths must be positive");
   end

   logic          valid_q;
   logic [IW-1:0] instr_q;
   logic [AW-1:0] pc_q;
   logic          load;

   assign load = ~kill_i & ~stall_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         valid_q <= 1'b0;
         instr_q <= NOP_WORD;
         pc_q    <= '0;
      end else if (kill_i) begin
         valid_q <= 1'b0;
         instr_q <= NOP_WORD;
      end else if (load) begin
         valid_q <= 1'b1;
         instr_q <= word_i;
         pc_q    <= fpc_i;
      end
   end

   assign valid_o = valid_q;
   assign instr_o = instr_q;
   assign pc_o    = pc_q;

   // R7
   lane_kill_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      kill_i |=> (!valid_o && instr_o == NOP_WORD));

   // R6
   lane_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!kill_i && !stall_i) |=> (valid_o && instr_o == $past(word_i) && pc_o == $past(fpc_i)));

   // R5
   lane_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!kill_i && stall_i) |=> ($stable(valid_o) && $stable(instr_o) && $stable(pc_o)));

endmodule

// File: rtl/fetch_pair_pc.sv
module fetch_pair_pc #(
   parameter int AW                   = 16,
   parameter int IW                   = 16,
   parameter int LANES                = 2,
   parameter logic [IW-1:0] NOP_WORD  = '0,
   parameter bit REDIRECT_BEATS_STALL = 1'b1,
   parameter bit SQUASH_ON_REDIRECT   = 1'b0
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 redirect_i,
   input  logic [AW-1:0]        target_i,
   input  logic                 stall_i,
   input  logic [LANES-1:0]     squash_i,
   output logic [LANES*AW-1:0]  imem_addr_o,
   input  logic [LANES*IW-1:0]  imem_rdata_i,
   output logic [LANES-1:0]     dec_valid_o,
   output logic [LANES*IW-1:0]  dec_instr_o,
   output logic [LANES*AW-1:0]  dec_pc_o
);

   localparam int Step = LANES;

   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("fetch_pair_pc: LANES out of range");
   end

   logic [AW-1:0]    pc;
   logic [LANES-1:0] kill;

   fpc_pc_reg #(
      .AW                   (AW),
      .STEP                 (Step),
      .REDIRECT_BEATS_STALL (REDIRECT_BEATS_STALL),
      .RESET_PC             ('0)
   ) u_pc (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .redirect_i (redirect_i),
      .target_i   (target_i),
      .stall_i    (stall_i),
      .pc_o       (pc)
   );

   fpc_addr_gen #(
      .AW    (AW),
      .LANES (LANES)
   ) u_addr (
      .pc_i   (pc),
      .addr_o (imem_addr_o)
   );

   // Variant: redirect may also nullify every lane on its own
   if (SQUASH_ON_REDIRECT) begin : g_kill_redir
      assign kill = squash_i | {LANES{redirect_i}};
   end else begin : g_kill_plain
      assign kill = squash_i;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      fpc_lane_hold #(
         .AW       (AW),
         .IW       (IW),
         .NOP_WORD (NOP_WORD)
      ) u_hold (
         .clk_i   (clk_i),
         .rst_i   (rst_i),
         .kill_i  (kill[i]),
         .stall_i (stall_i),
         .word_i  (imem_rdata_i[i*IW +: IW]),
         .fpc_i   (imem_addr_o[i*AW +: AW]),
         .valid_o (dec_valid_o[i]),
         .instr_o (dec_instr_o[i*IW +: IW]),
         .pc_o    (dec_pc_o[i*AW +: AW])
      );
   end

   // R2
   lane_adjacent_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (LANES < 2) || (imem_addr_o[2*AW-1:AW] == imem_addr_o[AW-1:0] + AW'(1)));

   // R6
   pair_pc_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (LANES < 2) || !(&dec_valid_o[1:0]) || (dec_pc_o[2*AW-1:AW] == dec_pc_o[AW-1:0] + AW'(1)));

endmodule

// File: tb/sim_fetch_pair_pc.sv
module sim_fetch_pair_pc;

   localparam int AW = 16;
   localparam int IW = 16;
   localparam int NV = 12;

   typedef struct packed {
      logic        redir;
      logic [15:0] tgt;
      logic        stall;
      logic [1:0]  sq;
      logic [15:0] exp_pc;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{1'b0, 16'h0000, 1'b0, 2'b00, 16'h0002},
      '{1'b0, 16'h0000, 1'b0, 2'b00, 16'h0004},
      '{1'b0, 16'h0000, 1'b1, 2'b00, 16'h0004},
      '{1'b0, 16'h0000, 1'b1, 2'b01, 16'h0004},
      '{1'b1, 16'h0100, 1'b0, 2'b00, 16'h0100},
      '{1'b1, 16'h0200, 1'b1, 2'b00, 16'h0200},
      '{1'b0, 16'h0000, 1'b0, 2'b10, 16'h0202},
      '{1'b0, 16'h0000, 1'b0, 2'b11, 16'h0204},
      '{1'b1, 16'hFFFF, 1'b0, 2'b00, 16'hFFFF},
      '{1'b0, 16'h0000, 1'b0, 2'b00, 16'h0001},
      '{1'b1, 16'h0007, 1'b0, 2'b00, 16'h0007},
      '{1'b0, 16'h0000, 1'b0, 2'b00, 16'h0009}
   };

   logic          clk = 1'b0;
   logic          rst;
   logic          redirect;
   logic [AW-1:0] target;
   logic          stall;
   logic [1:0]    squash;
   logic [2*AW-1:0] imem_addr;
   logic [2*IW-1:0] imem_rdata;
   logic [1:0]      dec_valid;
   logic [2*IW-1:0] dec_instr;
   logic [2*AW-1:0] dec_pc;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   function automatic logic [IW-1:0] mem_word(input logic [AW-1:0] a);
      return {a[7:0], a[15:8]} ^ 16'h5A3C;
   endfunction

   always_comb begin
      imem_rdata[IW-1:0]    = mem_word(imem_addr[AW-1:0]);
      imem_rdata[2*IW-1:IW] = mem_word(imem_addr[2*AW-1:AW]);
   end

   fetch_pair_pc u0 (
      .clk_i        (clk),
      .rst_i        (rst),
      .redirect_i   (redirect),
      .target_i     (target),
      .stall_i      (stall),
      .squash_i     (squash),
      .imem_addr_o  (imem_addr),
      .imem_rdata_i (imem_rdata),
      .dec_valid_o  (dec_valid),
      .dec_instr_o  (dec_instr),
      .dec_pc_o     (dec_pc)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Bench model of the holding registers
   logic          mv [2];
   logic [IW-1:0] mi [2];
   logic [AW-1:0] mp [2];
   logic [AW-1:0] mpc;

   task automatic check_state(input string tag);
      chk(imem_addr[AW-1:0] == mpc, {tag, " R2 lane0 addr"}, 32'(imem_addr[AW-1:0]), 32'(mpc));
      chk(imem_addr[2*AW-1:AW] == mpc + 16'd1, {tag, " R2 lane1 addr"},
          32'(imem_addr[2*AW-1:AW]), 32'(mpc + 16'd1));
      for (int i = 0; i < 2; i++) begin
         chk(dec_valid[i] == mv[i], {tag, " R6/R7 valid"}, 32'(dec_valid[i]), 32'(mv[i]));
         chk(dec_instr[i*IW +: IW] == mi[i], {tag, " R6/R7 instr"},
             32'(dec_instr[i*IW +: IW]), 32'(mi[i]));
         if (mv[i]) begin
            chk(dec_pc[i*AW +: AW] == mp[i], {tag, " R6 lane pc"},
                32'(dec_pc[i*AW +: AW]), 32'(mp[i]));
         end
      end
   endtask

   task automatic step(input logic r, input logic [15:0] t, input logic s, input logic [1:0] q);
      redirect = r;
      target   = t;
      stall    = s;
      squash   = q;
      for (int i = 0; i < 2; i++) begin
         if (q[i]) begin
            mv[i] = 1'b0;
            mi[i] = 16'h0000;
         end else if (!s) begin
            mv[i] = 1'b1;
            mi[i] = mem_word(mpc + 16'(i));
            mp[i] = mpc + 16'(i);
         end
      end
      if (r) mpc = t;
      else if (!s) mpc = mpc + 16'd2;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic reset_model();
      mpc = 16'h0000;
      for (int i = 0; i < 2; i++) begin
         mv[i] = 1'b0;
         mi[i] = 16'h0000;
         mp[i] = 16'h0000;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      rst = 1'b1; redirect = 1'b0; target = '0; stall = 1'b0; squash = 2'b00;
      reset_model();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: state during reset
      check_state("R1 in reset");
      rst = 1'b0;
      // R1: state before the first edge after reset
      check_state("R1 after release");

      // Vector table: R3 step, R4 redirect (also under stall), R5 stall, R7 squash, R2 wrap
      for (int v = 0; v < NV; v++) begin
         step(VECS[v].redir, VECS[v].tgt, VECS[v].stall, VECS[v].sq);
         chk(mpc == VECS[v].exp_pc, "R3/R4/R5 table pc", 32'(mpc), 32'(VECS[v].exp_pc));
         check_state($sformatf("vec %0d", v));
      end

      // R5: long stall keeps everything frozen
      step(1'b0, 16'h0000, 1'b1, 2'b00);
      step(1'b0, 16'h0000, 1'b1, 2'b00);
      check_state("R5 long stall");

      // R7: squash of lane 1 under stall leaves lane 0 frozen
      step(1'b0, 16'h0000, 1'b1, 2'b10);
      check_state("R7 squash under stall");

      // R4: back-to-back redirects
      step(1'b1, 16'h1234, 1'b0, 2'b00);
      step(1'b1, 16'hFFFE, 1'b1, 2'b11);
      step(1'b0, 16'h0000, 1'b0, 2'b00);
      check_state("R4 chained redirect wrap");

      // R1: reset in the middle of a redirect
      rst = 1'b1;
      redirect = 1'b1; target = 16'h4444;
      @(posedge clk);
      @(negedge clk);
      reset_model();
      rst = 1'b0; redirect = 1'b0;
      check_state("R1 mid-run reset");
      step(1'b0, 16'h0000, 1'b0, 2'b00);
      check_state("R6 first fetch after reset");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule